// File: doc/BRIEF.md
# Halfword Sign-Extend Execute Stage

This block is a single registered execute stage for one integer instruction. The instruction promotes the low 16 bits of a 64-bit source register to a signed 64-bit value. Each cycle the stage can accept a 32-bit instruction word, together with the value already read for its source register and the current summary-overflow bit.

The stage decodes the word and checks that it is the halfword sign-extend instruction. It takes the register indices from the word. One clock later it presents a destination index and the 64-bit result with a write enable. When the record bit is set, it also presents a 4-bit condition field with its own write enable. If a word is not this instruction, the stage raises a one-cycle unhandled flag so that another unit can deal with it.

The stage holds no register file. The source value and the summary-overflow bit come from outside, already read. The stage never changes the overflow state.

Top module: `halfword_sext_unit`

## Requirements
- R1: An instruction word (bit 31 of the word is the most significant bit, bit 0 the least) matches when word[31:26] equals 31 and word[10:1] equals 922. A matching word with in_valid high sets out_result_we high at the next rising edge, and out_dst_idx then equals word[20:16].
- R2: The result equals src_value[15:0] with bit 15 copied into all of bits 63:16.
- R3: The result does not depend on src_value[63:16] or on word[15:11]. The source index field word[25:21] may name the same register as the destination without any effect on the result.
- R4: When word[0] (the record bit) is 0, out_cond_we stays low.
- R5: When word[0] is 1 on a matching word, out_cond_we goes high with the result. out_cond is packed {LT,GT,EQ,SO} from bit 3 down to bit 0. LT, GT and EQ come from a signed comparison of the result with zero, and exactly one of them is set.
- R6: The SO bit of out_cond (bit 0) equals sum_ovf_in as sampled with the instruction.
- R7: A valid word that does not match keeps both write enables low and sets out_unhandled high for exactly that one output cycle.
- R8: When in_valid is low, the next cycle shows out_result_we, out_cond_we and out_unhandled all low.
- R9: While rst_n is low at a rising edge, out_result_we, out_cond_we and out_unhandled are cleared.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word and operands are valid this cycle |
| instr_word | input | 32 | Instruction word |
| src_value | input | 64 | Value of the source register |
| sum_ovf_in | input | 1 | Current summary-overflow bit |
| out_dst_idx | output | 5 | Destination register index |
| out_result | output | 64 | Sign-extended result |
| out_result_we | output | 1 | Result write enable |
| out_cond | output | 4 | Condition field {LT,GT,EQ,SO} |
| out_cond_we | output | 1 | Condition field write enable |
| out_unhandled | output | 1 | Valid word was not this instruction |

## Verification
Every output (enables, index, result, condition field and unhandled flag) passes through exactly one register. Each output is therefore due at the first rising edge after the cycle in which its inputs were driven. The driver applies each item at a falling edge and queues the expected outputs at the same moment, one item per cycle, idle cycles included. The monitor pops one item 2 ns after each rising edge, so every comparison lands on the edge where that item's outputs first appear.

// File: rtl/hsx_pkg.sv
package hsx_pkg;

   localparam int INSTR_W = 32;
   localparam int IDX_W   = 5;
   localparam int MAJOR_W = 6;
   localparam int MINOR_W = 10;

   // Field order is the instruction layout, most significant first.
   typedef struct packed {
      logic [MAJOR_W-1:0] major;
      logic [IDX_W-1:0]   src_idx;
      logic [IDX_W-1:0]   dst_idx;
      logic [IDX_W-1:0]   spare_idx;
      logic [MINOR_W-1:0] minor;
      logic               record;
   } xform_t;

   typedef struct packed {
      logic lt;
      logic gt;
      logic eq;
      logic so;
   } cond_t;

endpackage

// File: rtl/hsx_decode.sv
module hsx_decode
   import hsx_pkg::*;
#(
   parameter int unsigned MAJOR = 31,
   parameter int unsigned MINOR = 922
) (
   input  logic [INSTR_W-1:0] word,
   output xform_t             fields,
   output logic               hit
);
   localparam logic [MAJOR_W-1:0] MAJOR_C = MAJOR_W'(MAJOR);
   localparam logic [MINOR_W-1:0] MINOR_C = MINOR_W'(MINOR);

   initial begin
      assert (MAJOR < (1 << MAJOR_W)) else $error("MAJOR does not fit its field");
      assert (MINOR < (1 << MINOR_W)) else $error("MINOR does not fit its field");
      assert ($bits(xform_t) == INSTR_W) else $error("field layout width mismatch");
   end

   always_comb begin
      fields = xform_t'(word);
      hit    = (fields.major == MAJOR_C) && (fields.minor == MINOR_C);
   end
endmodule

// File: rtl/hsx_sext.sv
module hsx_sext #(
   parameter int XLEN  = 64,
   parameter int SRC_W = 16
) (
   input  logic [XLEN-1:0] src,
   output logic [XLEN-1:0] res
);
   localparam int EXT_W = XLEN - SRC_W;

   initial begin
      assert (SRC_W > 0 && SRC_W <= XLEN) else $error("SRC_W out of range");
   end

   assign res[SRC_W-1:0] = src[SRC_W-1:0];

   generate
      if (EXT_W > 0) begin : g_extend
         logic unused_upper;
         assign unused_upper = ^src[XLEN-1:SRC_W];
         for (genvar b = SRC_W; b < XLEN; b++) begin : g_bit
            assign res[b] = src[SRC_W-1];
         end
      end
   endgenerate
endmodule

// File: rtl/hsx_cond.sv
module hsx_cond
   import hsx_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [XLEN-1:0] value,
   input  logic            so_in,
   output cond_t           field
);
   initial begin
      assert (XLEN >= 2) else $error("XLEN too small");
   end

   always_comb begin
      field.lt = value[XLEN-1];
      field.eq = (value == '0);
      field.gt = !field.lt && !field.eq;
      field.so = so_in;
   end
endmodule

// File: rtl/halfword_sext_unit.sv
module halfword_sext_unit
   import hsx_pkg::*;
#(
   parameter int          XLEN   = 64,
   parameter int          HALF_W = 16,
   parameter int unsigned MAJOR  = 31,
   parameter int unsigned MINOR  = 922
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [INSTR_W-1:0]   instr_word,
   input  logic [XLEN-1:0]      src_value,
   input  logic                 sum_ovf_in,
   output logic [IDX_W-1:0]     out_dst_idx,
   output logic [XLEN-1:0]      out_result,
   output logic                 out_result_we,
   output logic [3:0]           out_cond,
   output logic                 out_cond_we,
   output logic                 out_unhandled
);
   localparam int EXT_W = XLEN - HALF_W;

   initial begin
      assert (HALF_W < XLEN) else $error("HALF_W must be narrower than XLEN");
   end

   xform_t          fields;
   logic            hit;
   logic [XLEN-1:0] ext_value;
   cond_t           cond_next;
   logic            unused_fields;

   assign unused_fields = ^{fields.src_idx, fields.spare_idx};

   hsx_decode #(.MAJOR(MAJOR), .MINOR(MINOR)) u_decode (
      .word   (instr_word),
      .fields (fields),
      .hit    (hit)
   );

   hsx_sext #(.XLEN(XLEN), .SRC_W(HALF_W)) u_sext (
      .src (src_value),
      .res (ext_value)
   );

   hsx_cond #(.XLEN(XLEN)) u_cond (
      .value (ext_value),
      .so_in (sum_ovf_in),
      .field (cond_next)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_result_we <= 1'b0;
         out_cond_we   <= 1'b0;
         out_unhandled <= 1'b0;
         out_dst_idx   <= '0;
         out_result    <= '0;
         out_cond      <= '0;
      end else begin
         out_result_we <= in_valid && hit;
         out_cond_we   <= in_valid && hit && fields.record;
         out_unhandled <= in_valid && !hit;
         if (in_valid && hit) begin
            out_dst_idx <= fields.dst_idx;
            out_result  <= ext_value;
            out_cond    <= cond_next;
         end
      end
   end

   assert_match_writes_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && hit) |=> (out_result_we && out_dst_idx == $past(instr_word[20:16])));

   assert_upper_copies_sign_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_result_we |-> (out_result[XLEN-1:HALF_W] == {EXT_W{out_result[HALF_W-1]}}));

   assert_low_half_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && hit) |=> (out_result[HALF_W-1:0] == $past(src_value[HALF_W-1:0])));

   assert_no_cond_plain_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !instr_word[0]) |=> !out_cond_we);

   assert_one_relation_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_cond_we |-> ($countones(out_cond[3:1]) == 1 && out_result_we));

   assert_so_copied_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && hit && instr_word[0]) |=> (out_cond[0] == $past(sum_ovf_in)));

   assert_unhandled_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_unhandled |-> (!out_result_we && !out_cond_we));

   assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_result_we && !out_cond_we && !out_unhandled));
endmodule

// File: tb/halfword_sext_unit_tb_top.sv
module halfword_sext_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] instr_word = '0;
   logic [63:0] src_value = '0;
   logic        sum_ovf_in = 1'b0;
   logic [4:0]  out_dst_idx;
   logic [63:0] out_result;
   logic        out_result_we;
   logic [3:0]  out_cond;
   logic        out_cond_we;
   logic        out_unhandled;

   always #5 clk = ~clk;

   halfword_sext_unit dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .in_valid      (in_valid),
      .instr_word    (instr_word),
      .src_value     (src_value),
      .sum_ovf_in    (sum_ovf_in),
      .out_dst_idx   (out_dst_idx),
      .out_result    (out_result),
      .out_result_we (out_result_we),
      .out_cond      (out_cond),
      .out_cond_we   (out_cond_we),
      .out_unhandled (out_unhandled)
   );

   typedef struct {
      bit        we;
      bit [4:0]  dst;
      bit [63:0] res;
      bit        cwe;
      bit [3:0]  cond;
      bit        unh;
      string     tag;
   } exp_t;

   exp_t q[$];
   int   n_chk  = 0;
   int   n_fail = 0;
   bit   done   = 0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input int op, input int s, input int d,
                                      input int spare, input int xo, input bit rec);
      return {op[5:0], s[4:0], d[4:0], spare[4:0], xo[9:0], rec};
   endfunction

   task automatic drive(input bit v, input logic [31:0] w, input logic [63:0] s,
                        input bit so, input string tag);
      exp_t e;
      bit   hit;
      @(negedge clk);
      in_valid   = v;
      instr_word = w;
      src_value  = s;
      sum_ovf_in = so;
      hit   = (w[31:26] == 6'd31) && (w[10:1] == 10'd922);
      e.we  = v && hit;
      e.cwe = v && hit && w[0];
      e.unh = v && !hit;
      e.dst = w[20:16];
      e.res = {{48{s[15]}}, s[15:0]};
      if ($signed(e.res) < 0)       e.cond = {3'b100, so};
      else if (e.res == 64'd0)      e.cond = {3'b001, so};
      else                          e.cond = {3'b010, so};
      e.tag = tag;
      q.push_back(e);
   endtask

   initial begin : monitor
      forever begin
         @(posedge clk);
         #2;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk(out_result_we === e.we, e.tag, "result_we", 64'(out_result_we), 64'(e.we));
            chk(out_cond_we === e.cwe, e.tag, "cond_we", 64'(out_cond_we), 64'(e.cwe));
            chk(out_unhandled === e.unh, e.tag, "unhandled", 64'(out_unhandled), 64'(e.unh));
            if (e.we) begin
               chk(out_result === e.res, e.tag, "result", out_result, e.res);
               chk(out_dst_idx === e.dst, e.tag, "dst_idx", 64'(out_dst_idx), 64'(e.dst));
            end
            if (e.cwe)
               chk(out_cond === e.cond, e.tag, "cond", 64'(out_cond), 64'(e.cond));
         end
      end
   end

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : driver
      // R9: reset state, checked after two edges with reset held low
      in_valid   = 1'b1;
      instr_word = mk(31, 3, 4, 0, 922, 1'b1);
      src_value  = 64'h1;
      repeat (2) @(posedge clk);
      #2;
      chk(out_result_we === 1'b0, "R9", "result_we", 64'(out_result_we), 64'd0);
      chk(out_cond_we === 1'b0, "R9", "cond_we", 64'(out_cond_we), 64'd0);
      chk(out_unhandled === 1'b0, "R9", "unhandled", 64'(out_unhandled), 64'd0);
      @(negedge clk);
      in_valid = 1'b0;
      rst_n    = 1'b1;

      // R1/R2/R4: largest positive halfword, plain form
      drive(1, mk(31, 1, 2, 0, 922, 1'b0), 64'h0000_0000_0000_7FFF, 1'b0, "R1");
      // R2/R5: most negative halfword, record form
      drive(1, mk(31, 5, 6, 0, 922, 1'b1), 64'h0000_0000_0000_8000, 1'b0, "R5");
      // R2/R5/R6: minus one with SO set
      drive(1, mk(31, 7, 8, 0, 922, 1'b1), 64'h0000_0000_0000_FFFF, 1'b1, "R6");
      // R5/R6: zero result sets EQ, SO carried
      drive(1, mk(31, 9, 10, 0, 922, 1'b1), 64'h0000_0000_0000_0000, 1'b1, "R5");
      // R4: zero in plain form writes no condition field
      drive(1, mk(31, 9, 11, 0, 922, 1'b0), 64'h0000_0000_0000_0000, 1'b1, "R4");
      // R3: nonzero upper bits, spare field set, same source and destination
      drive(1, mk(31, 3, 3, 31, 922, 1'b1), 64'hDEAD_BEEF_1234_8001, 1'b0, "R3");
      drive(1, mk(31, 12, 12, 21, 922, 1'b1), 64'hFFFF_FFFF_FFFF_0042, 1'b1, "R3");
      drive(1, mk(31, 0, 31, 7, 922, 1'b0), 64'h8000_0000_0000_7FFF, 1'b0, "R2");
      // R8: idle cycle in between
      drive(0, mk(31, 1, 2, 0, 922, 1'b1), 64'h0000_0000_0000_8000, 1'b1, "R8");
      // R7: wrong primary opcode and wrong extended opcode
      drive(1, mk(30, 1, 2, 0, 922, 1'b1), 64'h0000_0000_0000_8000, 1'b0, "R7");
      drive(1, mk(31, 1, 2, 0, 954, 1'b1), 64'h0000_0000_0000_8000, 1'b0, "R7");
      // R7: unhandled lasts one cycle only, next item is a hit
      drive(1, mk(31, 4, 17, 0, 922, 1'b1), 64'h0000_0000_0000_0001, 1'b0, "R7");
      // R1: back-to-back hits
      drive(1, mk(31, 2, 20, 0, 922, 1'b1), 64'h1111_2222_3333_C000, 1'b1, "R1");
      drive(1, mk(31, 2, 21, 0, 922, 1'b0), 64'h0000_0000_0000_1234, 1'b0, "R1");
      drive(0, 32'h0, 64'h0, 1'b0, "R8");
      drive(0, 32'h0, 64'h0, 1'b0, "R8");

      repeat (3) @(posedge clk);
      #3;
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule